// File: doc/BRIEF.md
# Indexed Bank-Select Register Controller

This block is the register side of a cartridge banking controller. Software writes a command byte first. The command names a target index and carries two mode flags. The next data write then loads the pattern slots (1 KB each) or the program windows (8 KB each) that the index and flags select. The block drives the eight pattern slot numbers and the three program window numbers to the address translation logic, which lies outside it.

The same write port also reaches three other things:
- a mirroring select bit;
- a down-counter interrupt with a latch, a reload flag and a mode bit;
- an enable and acknowledge for that interrupt.

The counter steps once for each pulse on a clock-enable input. The logic that produces those pulses lies outside the block. The stored counter mode is an output, so that logic can pick the event that drives `cnt_tick`.

Only address bits 15:12 and 1:0 take part in decoding. Bits 11:2 are ignored, so each register appears at many aliased addresses.

Top module: `bank_cmd_ctrl`

## Requirements
- R1: A write to address 0x8000 sets the command. Data bits 3:0 are the target index, bit 6 is the program-swap flag and bit 7 is the pattern-flip flag. Later data writes follow the command's index and flags.
- R2: A data write to address 0x8001 with index 0 loads slot 0 with the data and slot 1 with data+1. With index 1 it loads slot 2 with the data and slot 3 with data+1. The +1 wraps modulo 256. When the pattern-flip flag is set, the pair goes to slots 4/5 (index 0) or 6/7 (index 1).
- R3: A data write with index 2, 3, 4 or 5 loads slot 4, 5, 6 or 7 in that order. When the pattern-flip flag is set it loads slot 0, 1, 2 or 3 instead.
- R4: A data write with index 8 loads slot 1, and one with index 9 loads slot 3. Neither flag changes these targets.
- R5: A data write with index 6 loads program window 0, or window 1 when the program-swap flag is set. Index 7 loads window 1, or window 2 when the flag is set. Index 15 loads window 2, or window 0 when the flag is set. `prg_bank_o[8*j +: 8]` holds window j.
- R6: A write to address 0xA000 sets `mirror_h` to data bit 0. The value 1 means horizontal mirroring and 0 means vertical.
- R7: A write to 0xC000 sets the latch. A write to 0xC001 does three things: it sets the reload flag, copies the latch into the counter, and drives data bit 0 onto `cnt_mode` from the next cycle.
- R8: A write to 0xE000 disables the interrupt and clears `irq` in the next cycle. A write to 0xE001 enables the interrupt. While the reload flag is set, either write also copies the latch into the counter.
- R9: Each `cnt_tick` pulse decrements the counter. A tick with the counter at 1 and the interrupt enabled sets `irq` at that clock edge and reloads the counter from the latch. If the interrupt is disabled, the same tick leaves the counter at 0, and a tick at 0 wraps the counter to 255.
- R10: Data writes with index 10 to 14 change nothing. Writes whose masked address is not one of the seven listed addresses also change nothing. Address bits 11:2 are ignored, so 0x8FFD acts as 0x8001.
- R11: After reset every pattern slot and program window is 0, and `mirror_h`, `irq` and `cnt_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| cnt_tick | input | 1 | Counter clock enable |
| pat_bank_o | output | 64 | Eight pattern slot numbers, slot k at bits 8k+7:8k |
| prg_bank_o | output | 24 | Three program window numbers, window j at bits 8j+7:8j |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| cnt_mode | output | 1 | Stored counter mode |
| irq | output | 1 | Interrupt request, level |

## Verification
Most faults in the stored index or flags stay hidden until the next data write. That write then lands in the wrong slot, and the fault shows one cycle later as a changed value in an untouched slot. The bench compares every slot and window after every write, so a slot that was wrongly left alone and a slot that was wrongly touched both show up.

Faults in the counter or the reload flag show up through the count of ticks before `irq`. The bench steps through the interrupt sequence one cycle at a time and compares `irq` every cycle. A counter that is off by one, or reloaded from the wrong source, therefore shows within a single reload period.

// File: rtl/bank_cmd_ctrl.sv
module bank_cmd_ctrl #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [15:0]     wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            cnt_tick,
  output logic [8*DW-1:0] pat_bank_o,
  output logic [3*DW-1:0] prg_bank_o,
  output logic            mirror_h,
  output logic            cnt_mode,
  output logic            irq
);
  localparam int NPAT = 8;
  localparam int NPRG = 3;
  localparam logic [5:0] K_CMD = 6'b100000;
  localparam logic [5:0] K_DAT = 6'b100001;
  localparam logic [5:0] K_MIR = 6'b101000;
  localparam logic [5:0] K_LAT = 6'b110000;
  localparam logic [5:0] K_RLD = 6'b110001;
  localparam logic [5:0] K_OFF = 6'b111000;
  localparam logic [5:0] K_ON  = 6'b111001;

  wire [5:0] key = {wr_addr[15:12], wr_addr[1:0]};
  wire cmd_wr = wr_en && key == K_CMD;
  wire dat_wr = wr_en && key == K_DAT;

  logic [3:0] idx_q;
  logic       swap_q, flip_q;
  logic [DW-1:0] latch_q, cnt_q;
  logic reload_q, en_q;

  always_ff @(posedge clk)
    if (!rst_n) begin
      idx_q <= '0; swap_q <= 1'b0; flip_q <= 1'b0;
    end else if (cmd_wr) begin
      idx_q <= wr_data[3:0]; swap_q <= wr_data[6]; flip_q <= wr_data[7];
    end

  logic [NPAT-1:0] pat_we;
  logic [DW-1:0]   pat_val [NPAT];
  logic [NPRG-1:0] prg_we;
  logic [2:0]      pair_lo, single;

  assign pair_lo = {flip_q, idx_q[0], 1'b0};
  assign single  = {~flip_q, idx_q[1:0] + 2'd2};

  always_comb begin
    pat_we = '0;
    prg_we = '0;
    for (int k = 0; k < NPAT; k++) pat_val[k] = wr_data;
    if (dat_wr) begin
      case (idx_q)
        4'd0, 4'd1: begin
          pat_we[pair_lo] = 1'b1;
          pat_we[pair_lo + 3'd1] = 1'b1;
          pat_val[pair_lo + 3'd1] = wr_data + DW'(1);
        end
        4'd2, 4'd3, 4'd4, 4'd5: pat_we[single] = 1'b1;
        4'd8: pat_we[1] = 1'b1;
        4'd9: pat_we[3] = 1'b1;
        4'd6:  prg_we[swap_q ? 1 : 0] = 1'b1;
        4'd7:  prg_we[swap_q ? 2 : 1] = 1'b1;
        4'd15: prg_we[swap_q ? 0 : 2] = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NPAT; k++) begin : g_pat
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk)
      if (!rst_n) slot_q <= '0;
      else if (pat_we[k]) slot_q <= pat_val[k];
    assign pat_bank_o[k*DW +: DW] = slot_q;
  end

  for (genvar j = 0; j < NPRG; j++) begin : g_prg
    logic [DW-1:0] win_q;
    always_ff @(posedge clk)
      if (!rst_n) win_q <= '0;
      else if (prg_we[j]) win_q <= wr_data;
    assign prg_bank_o[j*DW +: DW] = win_q;
  end

  always_ff @(posedge clk)
    if (!rst_n) mirror_h <= 1'b0;
    else if (wr_en && key == K_MIR) mirror_h <= wr_data[0];

  always_ff @(posedge clk)
    if (!rst_n) begin
      latch_q <= '0; cnt_q <= '0; reload_q <= 1'b0;
      en_q <= 1'b0; irq <= 1'b0; cnt_mode <= 1'b0;
    end else begin
      if (cnt_tick) begin
        if (cnt_q == DW'(1)) begin
          if (en_q) begin
            cnt_q <= latch_q;
            irq   <= 1'b1;
          end else cnt_q <= '0;
        end else cnt_q <= cnt_q - DW'(1);
      end
      if (wr_en) begin
        case (key)
          K_LAT: latch_q <= wr_data;
          K_RLD: begin
            reload_q <= 1'b1;
            cnt_q    <= latch_q;
            cnt_mode <= wr_data[0];
          end
          K_OFF: begin
            en_q <= 1'b0;
            irq  <= 1'b0;
            if (reload_q) cnt_q <= latch_q;
          end
          K_ON: begin
            en_q <= 1'b1;
            if (reload_q) cnt_q <= latch_q;
          end
          default: ;
        endcase
      end
    end

  assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == K_OFF) |=> !irq);

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt_tick) && $past(en_q)));

  assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == K_MIR) |=> mirror_h == $past(wr_data[0]));

  assert_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_q >= 4'd10 && idx_q <= 4'd14) |=>
      ($stable(pat_bank_o) && $stable(prg_bank_o)));

  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx_q == 4'd0 && !flip_q) |=>
      pat_bank_o[DW +: DW] == DW'(pat_bank_o[0 +: DW] + DW'(1)));
endmodule

// File: tb/bank_cmd_ctrl_test.sv
module bank_cmd_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cnt_tick = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [63:0] pat_bank_o;
  logic [23:0] prg_bank_o;
  logic mirror_h, cnt_mode, irq;

  always #10 clk = ~clk;

  bank_cmd_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_tick(cnt_tick), .pat_bank_o(pat_bank_o),
    .prg_bank_o(prg_bank_o), .mirror_h(mirror_h), .cnt_mode(cnt_mode), .irq(irq));

  typedef struct {
    logic [63:0] pat; logic [23:0] prg;
    logic mir, irq, mode; int req;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_pat [8];
  logic [7:0] m_prg [3];
  logic [7:0] m_latch, m_cnt;
  logic [3:0] m_idx;
  logic m_swap, m_flip, m_mir, m_irq, m_mode, m_rel, m_en;

  task automatic model(input logic we, input logic [15:0] a, input logic [7:0] d, input logic tk);
    logic [15:0] k;
    k = a & 16'hF003;
    if (tk) begin
      if (m_cnt == 8'd1) begin
        if (m_en) begin m_cnt = m_latch; m_irq = 1'b1; end
        else m_cnt = 8'd0;
      end else m_cnt = m_cnt - 8'd1;
    end
    if (we) begin
      if (k == 16'h8000) begin m_idx = d[3:0]; m_swap = d[6]; m_flip = d[7]; end
      else if (k == 16'h8001) begin
        case (m_idx)
          0: begin m_pat[m_flip ? 4 : 0] = d; m_pat[m_flip ? 5 : 1] = d + 8'd1; end
          1: begin m_pat[m_flip ? 6 : 2] = d; m_pat[m_flip ? 7 : 3] = d + 8'd1; end
          2, 3, 4, 5: m_pat[(m_flip ? 0 : 4) + m_idx - 2] = d;
          8: m_pat[1] = d;
          9: m_pat[3] = d;
          6: m_prg[m_swap ? 1 : 0] = d;
          7: m_prg[m_swap ? 2 : 1] = d;
          15: m_prg[m_swap ? 0 : 2] = d;
          default: ;
        endcase
      end
      else if (k == 16'hA000) m_mir = d[0];
      else if (k == 16'hC000) m_latch = d;
      else if (k == 16'hC001) begin m_rel = 1'b1; m_cnt = m_latch; m_mode = d[0]; end
      else if (k == 16'hE000) begin m_en = 1'b0; m_irq = 1'b0; if (m_rel) m_cnt = m_latch; end
      else if (k == 16'hE001) begin m_en = 1'b1; if (m_rel) m_cnt = m_latch; end
    end
  endtask

  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                      input logic tk, input int req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; cnt_tick = tk;
    model(we, a, d, tk);
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) e.pat[i*8 +: 8] = m_pat[i];
    for (int j = 0; j < 3; j++) e.prg[j*8 +: 8] = m_prg[j];
    e.mir = m_mir; e.irq = m_irq; e.mode = m_mode; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int req);
    step(1'b1, a, d, 1'b0, req);
  endtask

  task automatic tick(input int req);
    step(1'b0, 16'h0000, 8'h00, 1'b1, req);
  endtask

  initial forever begin
    @(negedge clk);
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pat_bank_o !== e.pat || prg_bank_o !== e.prg || mirror_h !== e.mir ||
          irq !== e.irq || cnt_mode !== e.mode) begin
        fails++;
        $display("FAIL R%0d: pat=%h prg=%h mir=%b irq=%b mode=%b expected pat=%h prg=%h mir=%b irq=%b mode=%b",
          e.req, pat_bank_o, prg_bank_o, mirror_h, irq, cnt_mode,
          e.pat, e.prg, e.mir, e.irq, e.mode);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expected completion, got hang");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_pat[i] = 8'h00;
    for (int j = 0; j < 3; j++) m_prg[j] = 8'h00;
    m_latch = 0; m_cnt = 0; m_idx = 0; m_swap = 0; m_flip = 0;
    m_mir = 0; m_irq = 0; m_mode = 0; m_rel = 0; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 16'h0000, 8'h00, 1'b0, 11);               // R11 reset state
    // R1 R2: pairs, wrap of data+1, flip flag
    wr(16'h8000, 8'h00, 1); wr(16'h8001, 8'h10, 2);
    wr(16'h8000, 8'h01, 1); wr(16'h8001, 8'hFF, 2);
    wr(16'h8000, 8'h80, 1); wr(16'h8001, 8'h20, 2);
    wr(16'h8000, 8'h81, 1); wr(16'h8001, 8'h30, 2);
    // R3: single slots, both flip settings
    for (int i = 2; i <= 5; i++) begin
      wr(16'h8000, 8'(i), 3); wr(16'h8001, 8'(8'h40 + i), 3);
    end
    for (int i = 2; i <= 5; i++) begin
      wr(16'h8000, 8'(8'h80 | i), 3); wr(16'h8001, 8'(8'h50 + i), 3);
    end
    // R4: fixed targets with both flags set
    wr(16'h8000, 8'hC8, 4); wr(16'h8001, 8'h55, 4);
    wr(16'h8000, 8'h09, 4); wr(16'h8001, 8'h66, 4);
    // R5: program windows, swap off then on
    wr(16'h8000, 8'h06, 5); wr(16'h8001, 8'h01, 5);
    wr(16'h8000, 8'h07, 5); wr(16'h8001, 8'h02, 5);
    wr(16'h8000, 8'h0F, 5); wr(16'h8001, 8'h03, 5);
    wr(16'h8000, 8'h46, 5); wr(16'h8001, 8'h04, 5);
    wr(16'h8000, 8'h47, 5); wr(16'h8001, 8'h05, 5);
    wr(16'h8000, 8'h4F, 5); wr(16'h8001, 8'h06, 5);
    // R10: unused indices, undecoded addresses, alias
    for (int i = 10; i <= 14; i++) begin
      wr(16'h8000, 8'(i), 10); wr(16'h8001, 8'h99, 10);
    end
    wr(16'h9001, 8'hAA, 10); wr(16'h8002, 8'hAB, 10); wr(16'hF000, 8'hAC, 10);
    wr(16'h8000, 8'h00, 10); wr(16'h8FFD, 8'h70, 10);
    // R6: mirroring
    wr(16'hA000, 8'h01, 6); wr(16'hA7FC, 8'hFE, 6); wr(16'hA000, 8'h03, 6);
    // R7 R8 R9: interrupt sequence
    wr(16'hC000, 8'h03, 7); wr(16'hC001, 8'h01, 7);
    wr(16'hE001, 8'h00, 8);
    tick(9); tick(9); tick(9);                           // R9 irq on third tick
    tick(9);
    wr(16'hE000, 8'h00, 8);                              // R8 ack, reload to 3
    tick(9); tick(9); tick(9); tick(9);                  // R9 disabled: 2,1,0,wrap
    wr(16'hE001, 8'h00, 8);
    tick(9); tick(9); tick(9);
    wr(16'hE000, 8'h00, 8);
    wr(16'hC001, 8'h00, 7);
    step(1'b0, 16'h0000, 8'h00, 1'b0, 7);
    wait (q.size() == 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule